// File: doc/BRIEF.md
# Video Blank Timing Generator

This block derives the horizontal and vertical blanking rhythm of a video output from one free-running cycle counter. Both axes alternate between a render phase and a blank phase. At every phase boundary the block emits a one-cycle pulse: blank start or blank end, for each axis. These pulses feed general-purpose timers and an interrupt controller. The vertical blank start pulse drives interrupt line 2, and the vertical blank end pulse drives line 3.

Phase lengths come from a frame length input given in fixed point with 4 fraction bits (1/16 cycle). Two such inputs exist, one for each video standard. A mode bit selects one of them, together with that standard's scanline count. The scanline counts are parameters, 525 for mode 0 and 625 for mode 1.

Line and field lengths are rounded to whole cycles separately, so they drift apart. At every vertical blank start the block moves the line timer by the accumulated rounding error, which keeps lines locked to fields. A scanline counter lets a checker confirm the number of lines in each frame.

Top module: `blank_timing_gen`

## Requirements
- R1: During reset and in the first cycle after it, both axes are in render (`h_blank`=0, `v_blank`=0). In that cycle no pulse is raised, `line_cnt`=0, `frame_lines`=0 and `hstat_flag`=0. The cycle counter counts from 0 in that cycle.
- R2: Line length S is the frame value divided by the line count, truncated in 1/16-cycle units. The horizontal blank part is S/2 truncated, and render is the remainder, so an odd unit goes to render. `hblank_start` pulses when render has lasted its length. `hblank_end` pulses when blank has lasted its length, and the next line begins in that same cycle.
- R3: The half-frame H is the frame value halved and truncated in 1/16-cycle units. Vertical blank is H/2 truncated, and render is the remainder. Each frame therefore holds two render/blank pairs, and the pulses follow the same timing rule as R2.
- R4: For each axis, render is rounded to nearest (a fraction of 8/16 or more rounds up). Blank is then rounded to nearest only if render was not rounded up; otherwise blank is truncated.
- R5: At each `vblank_start`, the line timer's phase origin is shifted by E = (vrender+vblank) − ((hrender+hblank)·lines)/2, with integer truncation. E may be negative.
- R6: `vblank_start` and `vblank_end` strictly alternate, and the first one after reset is `vblank_start`.
- R7: `hblank_start` and `hblank_end` strictly alternate, and each is one cycle wide.
- R8: `hstat_flag` is set at `hblank_end` when `hstat_en`=1, and is unaffected when `hstat_en`=0. `hstat_clr` clears it, but a set in the same cycle wins.
- R9: Mode 0 uses `frame_a_fx` with LINES_A, and mode 1 uses `frame_b_fx` with LINES_B. Changes to the mode and frame inputs take effect only at `vblank_start`: the render interval in progress keeps its old length, and the blank that follows uses the new one.
- R10: `line_cnt` counts `hblank_end` pulses. At every second `vblank_end` after reset (the frame boundary), `frame_lines` takes the count, including a pulse in that same cycle, and `line_cnt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Standard select: 0 = set A, 1 = set B |
| frame_a_fx | input | 32 | Frame length for set A, in 1/16 cycles |
| frame_b_fx | input | 32 | Frame length for set B, in 1/16 cycles |
| hstat_en | input | 1 | Enables setting of the horizontal status flag |
| hstat_clr | input | 1 | Clears the horizontal status flag |
| h_blank | output | 1 | Horizontal phase: 1 = blank |
| v_blank | output | 1 | Vertical phase: 1 = blank |
| hblank_start | output | 1 | Horizontal blank start pulse |
| hblank_end | output | 1 | Horizontal blank end pulse |
| vblank_start | output | 1 | Vertical blank start pulse (interrupt line 2) |
| vblank_end | output | 1 | Vertical blank end pulse (interrupt line 3) |
| hstat_flag | output | 1 | Sticky horizontal status flag |
| line_cnt | output | $clog2(max lines+2) | Lines since the last frame boundary |
| frame_lines | output | $clog2(max lines+2) | Line count of the last complete frame |

## Verification
A cycle model in the bench is swept over many frame lengths, with fractions of 0, 5, 8 and 13 sixteenths, in both modes. The mode is flipped part way through each run, which separates correct deferral to the vertical blank start from an immediate switch. Hand-computed frame lengths isolate the cases that a single pattern cannot tell apart: render rounded up with blank truncated, blank rounded up, a positive line-timer shift, and an exact frame where the count must equal the configured lines. Runs with the status enable low, and with a clear pulse, distinguish set, hold and clear of the flag.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  localparam int TW = 32;  // cycle and length width
  localparam int FB = 4;   // fraction bits of the frame input

  typedef struct packed {
    logic [TW-1:0] vr;    // vertical render cycles
    logic [TW-1:0] vb;    // vertical blank cycles
    logic [TW-1:0] hr;    // horizontal render cycles
    logic [TW-1:0] hb;    // horizontal blank cycles
    logic [TW-1:0] herr;  // line timer shift per field, two's complement
  } vbt_timing_t;

  // Render rounds to nearest; blank rounds only when render did not round up.
  function automatic logic [2*TW-1:0] round_pair(input logic [TW-1:0] r_fx,
                                                 input logic [TW-1:0] b_fx);
    logic [TW-1:0] r;
    logic [TW-1:0] b;
    r = r_fx >> FB;
    b = b_fx >> FB;
    if (r_fx[FB-1])      r = r + 1'b1;
    else if (b_fx[FB-1]) b = b + 1'b1;
    return {r, b};
  endfunction

  function automatic vbt_timing_t calc_timing(input logic [TW-1:0] frame_fx,
                                              input logic [TW-1:0] lines);
    vbt_timing_t   t;
    logic [TW-1:0] half_fx, vb_fx, vr_fx, line_fx, hb_fx, hr_fx;
    logic [2*TW-1:0] pair;
    logic [2*TW-1:0] hsum;
    half_fx = frame_fx >> 1;
    vb_fx   = half_fx >> 1;
    vr_fx   = half_fx - vb_fx;
    line_fx = frame_fx / lines;
    hb_fx   = line_fx >> 1;
    hr_fx   = line_fx - hb_fx;
    pair = round_pair(vr_fx, vb_fx);
    t.vr = pair[2*TW-1:TW];
    t.vb = pair[TW-1:0];
    pair = round_pair(hr_fx, hb_fx);
    t.hr = pair[2*TW-1:TW];
    t.hb = pair[TW-1:0];
    hsum = ({{TW{1'b0}}, t.hr} + {{TW{1'b0}}, t.hb}) * {{TW{1'b0}}, lines};
    hsum = hsum >> 1;
    t.herr = t.vr + t.vb - hsum[TW-1:0];
    return t;
  endfunction
endpackage

// File: rtl/vbt_cfg.sv
module vbt_cfg import vbt_pkg::*; #(
  parameter int LINES_A = 525,
  parameter int LINES_B = 625
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [TW-1:0] frame_a_fx,
  input  logic [TW-1:0] frame_b_fx,
  input  logic          load,
  output vbt_timing_t   cur,
  output vbt_timing_t   pend
);
  localparam logic [TW-1:0] LA = TW'(LINES_A);
  localparam logic [TW-1:0] LB = TW'(LINES_B);

  vbt_timing_t cur_q;

  always_comb pend = mode_sel ? calc_timing(frame_b_fx, LB) : calc_timing(frame_a_fx, LA);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur_q <= pend;
    else if (load) cur_q <= pend;
  end

  assign cur = cur_q;

  // R9: lengths in use change only at a vertical blank start
  a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cur_q));
endmodule

// File: rtl/vbt_phase.sv
module vbt_phase import vbt_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cyc,
  input  logic [TW-1:0] len_render,
  input  logic [TW-1:0] len_blank,
  input  logic [TW-1:0] adj,
  input  logic          adj_en,
  output logic          in_blank,
  output logic          blank_start,
  output logic          blank_end
);
  logic [TW-1:0] start_q;
  logic          blank_q;
  logic [TW-1:0] len;
  logic [TW-1:0] elapsed;
  logic          hit;

  always_comb begin
    len     = blank_q ? len_blank : len_render;
    elapsed = cyc - start_q;
    hit     = $signed(elapsed) >= $signed(len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      blank_q <= 1'b0;
    end else begin
      start_q <= start_q + (hit ? len : '0) + (adj_en ? adj : '0);
      if (hit) blank_q <= ~blank_q;
    end
  end

  assign in_blank    = blank_q;
  assign blank_start = hit & ~blank_q;
  assign blank_end   = hit & blank_q;

  // R7: a blank start is never repeated on the next cycle
  a_r7_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
    blank_start |=> !blank_start);
endmodule

// File: rtl/vbt_lines.sv
module vbt_lines #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_done,
  input  logic          field_end,
  output logic [LW-1:0] line_cnt,
  output logic [LW-1:0] frame_lines
);
  logic          odd_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (field_end) odd_q <= ~odd_q;
      if (field_end && odd_q) begin
        last_q <= cnt_q + LW'(line_done);
        cnt_q  <= '0;
      end else if (line_done) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_cnt    = cnt_q;
  assign frame_lines = last_q;
endmodule

// File: rtl/blank_timing_gen.sv
module blank_timing_gen import vbt_pkg::*; #(
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  localparam int LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int LW   = $clog2(LMAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [TW-1:0] frame_a_fx,
  input  logic [TW-1:0] frame_b_fx,
  input  logic          hstat_en,
  input  logic          hstat_clr,
  output logic          h_blank,
  output logic          v_blank,
  output logic          hblank_start,
  output logic          hblank_end,
  output logic          vblank_start,
  output logic          vblank_end,
  output logic          hstat_flag,
  output logic [LW-1:0] line_cnt,
  output logic [LW-1:0] frame_lines
);
  logic [TW-1:0] cyc_q;
  vbt_timing_t   cur;
  vbt_timing_t   pend;
  logic          vbs_w, vbe_w, hbs_w, hbe_w;
  logic          flag_q;
  logic          vseen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + 1'b1;
  end

  vbt_cfg #(.LINES_A(LINES_A), .LINES_B(LINES_B)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .frame_a_fx(frame_a_fx), .frame_b_fx(frame_b_fx),
    .load(vbs_w), .cur(cur), .pend(pend)
  );

  vbt_phase u_vert (
    .clk(clk), .rst_n(rst_n), .cyc(cyc_q),
    .len_render(cur.vr), .len_blank(cur.vb),
    .adj('0), .adj_en(1'b0),
    .in_blank(v_blank), .blank_start(vbs_w), .blank_end(vbe_w)
  );

  vbt_phase u_horz (
    .clk(clk), .rst_n(rst_n), .cyc(cyc_q),
    .len_render(cur.hr), .len_blank(cur.hb),
    .adj(pend.herr), .adj_en(vbs_w),
    .in_blank(h_blank), .blank_start(hbs_w), .blank_end(hbe_w)
  );

  vbt_lines #(.LW(LW)) u_lines (
    .clk(clk), .rst_n(rst_n), .line_done(hbe_w), .field_end(vbe_w),
    .line_cnt(line_cnt), .frame_lines(frame_lines)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      vseen_q <= 1'b0;
    end else begin
      if (hbe_w && hstat_en) flag_q <= 1'b1;
      else if (hstat_clr)    flag_q <= 1'b0;
      if (vbs_w)      vseen_q <= 1'b1;
      else if (vbe_w) vseen_q <= 1'b0;
    end
  end

  assign hblank_start = hbs_w;
  assign hblank_end   = hbe_w;
  assign vblank_start = vbs_w;
  assign vblank_end   = vbe_w;
  assign hstat_flag   = flag_q;

  // R6: vertical start and end pulses alternate, start first
  a_r6_vbs_order: assert property (@(posedge clk) disable iff (!rst_n)
    vbs_w |-> !vseen_q);
  a_r6_vbe_order: assert property (@(posedge clk) disable iff (!rst_n)
    vbe_w |-> vseen_q);
  // R8: the flag only rises after an enabled horizontal blank end
  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hbe_w && hstat_en));
endmodule

// File: tb/tb_blank_timing_gen.sv
module tb_blank_timing_gen;
  localparam int LA = 5;
  localparam int LB = 7;
  localparam int LW = $clog2(LB + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic [31:0] frame_a_fx = 32'd1280;
  logic [31:0] frame_b_fx = 32'd1280;
  logic hstat_en = 1'b0;
  logic hstat_clr = 1'b0;
  logic h_blank, v_blank, hblank_start, hblank_end, vblank_start, vblank_end, hstat_flag;
  logic [LW-1:0] line_cnt, frame_lines;

  always #2.5 clk = ~clk;

  blank_timing_gen #(.LINES_A(LA), .LINES_B(LB)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .frame_a_fx(frame_a_fx), .frame_b_fx(frame_b_fx),
    .hstat_en(hstat_en), .hstat_clr(hstat_clr),
    .h_blank(h_blank), .v_blank(v_blank),
    .hblank_start(hblank_start), .hblank_end(hblank_end),
    .vblank_start(vblank_start), .vblank_end(vblank_end),
    .hstat_flag(hstat_flag), .line_cnt(line_cnt), .frame_lines(frame_lines)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  int unsigned m_cyc, hs, vs;
  bit hbl, vbl, m_flag, m_par;
  int m_lc, m_fl;
  int unsigned c_vr, c_vb, c_hr, c_hb;
  int c_err;
  // recorded DUT event times (cycles since reset)
  int hbs_at[8], hbe_at[8], vbs_at[4], vbe_at[4];
  int n_hbs, n_hbe, n_vbs, n_vbe;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Timing restated from the requirements: nearest rounding via +8/16.
  task automatic bcalc(input int unsigned ffx, input int unsigned l,
                       output int unsigned vr, output int unsigned vb,
                       output int unsigned hr, output int unsigned hb, output int er);
    int unsigned half, bf, rf, s;
    half = ffx / 2; bf = half / 2; rf = half - bf;
    vr = (rf + 8) / 16;
    vb = (vr * 16 > rf) ? bf / 16 : (bf + 8) / 16;
    s = ffx / l; bf = s / 2; rf = s - bf;
    hr = (rf + 8) / 16;
    hb = (hr * 16 > rf) ? bf / 16 : (bf + 8) / 16;
    er = int'(vr + vb) - int'(((hr + hb) * l) / 2);
  endtask

  task automatic pend_now(output int unsigned vr, output int unsigned vb,
                          output int unsigned hr, output int unsigned hb, output int er);
    if (mode_sel) bcalc(frame_b_fx, LB, vr, vb, hr, hb, er);
    else          bcalc(frame_a_fx, LA, vr, vb, hr, hb, er);
  endtask

  function automatic bit hhit();
    return int'(m_cyc - hs) >= int'(hbl ? c_hb : c_hr);
  endfunction
  function automatic bit vhit();
    return int'(m_cyc - vs) >= int'(vbl ? c_vb : c_vr);
  endfunction

  task automatic compare();
    bit eh, ev;
    eh = hhit(); ev = vhit();
    chk(hblank_start == (eh && !hbl), "R2 hblank_start", int'(hblank_start), int'(eh && !hbl));
    chk(hblank_end == (eh && hbl), "R2 hblank_end", int'(hblank_end), int'(eh && hbl));
    chk(h_blank == hbl, "R7 h_blank", int'(h_blank), int'(hbl));
    chk(vblank_start == (ev && !vbl), "R3 vblank_start", int'(vblank_start), int'(ev && !vbl));
    chk(vblank_end == (ev && vbl), "R3 vblank_end", int'(vblank_end), int'(ev && vbl));
    chk(v_blank == vbl, "R6 v_blank", int'(v_blank), int'(vbl));
    chk(hstat_flag == m_flag, "R8 hstat_flag", int'(hstat_flag), int'(m_flag));
    chk(int'(line_cnt) == m_lc, "R10 line_cnt", int'(line_cnt), m_lc);
    chk(int'(frame_lines) == m_fl, "R10 frame_lines", int'(frame_lines), m_fl);
    if (hblank_start && n_hbs < 8) begin hbs_at[n_hbs] = int'(m_cyc); n_hbs++; end
    if (hblank_end && n_hbe < 8) begin hbe_at[n_hbe] = int'(m_cyc); n_hbe++; end
    if (vblank_start && n_vbs < 4) begin vbs_at[n_vbs] = int'(m_cyc); n_vbs++; end
    if (vblank_end && n_vbe < 4) begin vbe_at[n_vbe] = int'(m_cyc); n_vbe++; end
  endtask

  task automatic model_update();
    int unsigned pvr, pvb, phr, phb, hl, vl;
    int per;
    bit eh, ev, vbs_e, vbe_e, hbe_e;
    pend_now(pvr, pvb, phr, phb, per);
    eh = hhit(); ev = vhit();
    hl = hbl ? c_hb : c_hr;
    vl = vbl ? c_vb : c_vr;
    vbs_e = ev && !vbl; vbe_e = ev && vbl; hbe_e = eh && hbl;
    if (eh) begin hs = hs + hl; hbl = !hbl; end
    if (vbs_e) hs = hs + unsigned'(per);            // R5 line timer shift
    if (ev) begin vs = vs + vl; vbl = !vbl; end
    if (vbs_e) begin c_vr = pvr; c_vb = pvb; c_hr = phr; c_hb = phb; c_err = per; end
    if (hbe_e && hstat_en) m_flag = 1'b1;
    else if (hstat_clr) m_flag = 1'b0;
    if (vbe_e && m_par) begin m_fl = m_lc + int'(hbe_e); m_lc = 0; end
    else if (hbe_e) m_lc++;
    if (vbe_e) m_par = !m_par;
    m_cyc++;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    pend_now(c_vr, c_vb, c_hr, c_hb, c_err);
    m_cyc = 0; hs = 0; vs = 0; hbl = 0; vbl = 0; m_flag = 0; m_par = 0; m_lc = 0; m_fl = 0;
    n_hbs = 0; n_hbe = 0; n_vbs = 0; n_vbe = 0;
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      summary();
    end
  end

  initial begin
    // R1: reset state, exact frame of 80 cycles, 5 lines
    mode_sel = 0; frame_a_fx = 32'd1280; hstat_en = 1; hstat_clr = 0;
    do_reset();
    chk(h_blank == 0 && v_blank == 0, "R1 phases", int'({h_blank, v_blank}), 0);
    chk({hblank_start, hblank_end, vblank_start, vblank_end} == 4'b0, "R1 pulses",
        int'({hblank_start, hblank_end, vblank_start, vblank_end}), 0);
    chk(line_cnt == 0 && frame_lines == 0 && hstat_flag == 0, "R1 counters",
        int'(line_cnt) + int'(frame_lines) + int'(hstat_flag), 0);
    step(163);
    chk(hbs_at[0] == 8, "R2 first hblank_start", hbs_at[0], 8);
    chk(hbe_at[0] == 16, "R2 first hblank_end", hbe_at[0], 16);
    chk(vbs_at[0] == 20, "R3 first vblank_start", vbs_at[0], 20);
    chk(vbe_at[0] == 40, "R3 first vblank_end", vbe_at[0], 40);
    chk(int'(frame_lines) == LA, "R10 lines per frame A", int'(frame_lines), LA);
    chk(hstat_flag == 1, "R8 flag set when enabled", int'(hstat_flag), 1);
    // R8: clear without a set
    hstat_en = 0; hstat_clr = 1;
    step(1);
    hstat_clr = 0;
    chk(hstat_flag == 0, "R8 flag cleared", int'(hstat_flag), 0);
    step(60);
    chk(hstat_flag == 0, "R8 flag ignores hblank_end when disabled", int'(hstat_flag), 0);

    // R4: render rounds up (5.5 -> 6 / 5), vertical 13.75 -> 14 / 13
    frame_a_fx = 32'd880;
    do_reset();
    step(60);
    chk(hbs_at[0] == 6, "R4 render rounded up", hbs_at[0], 6);
    chk(hbe_at[0] == 11, "R4 blank truncated", hbe_at[0], 11);
    chk(vbs_at[0] == 14, "R4 vrender rounded up", vbs_at[0], 14);
    chk(vbe_at[0] == 27, "R4 vblank truncated", vbe_at[0], 27);

    // R4: blank rounds up (4.9375 -> 5) when render is exact
    frame_a_fx = 32'd795;
    do_reset();
    step(30);
    chk(hbs_at[0] == 5, "R4 render exact", hbs_at[0], 5);
    chk(hbe_at[0] == 10, "R4 blank rounded up", hbe_at[0], 10);

    // R5: frame 83 cycles gives shift +1 at the vblank start at cycle 21
    frame_a_fx = 32'd1328;
    do_reset();
    step(40);
    chk(vbs_at[0] == 21, "R5 vblank_start", vbs_at[0], 21);
    chk(hbs_at[1] == 25, "R5 shifted hblank_start", hbs_at[1], 25);

    // R9: switch to set B during render; render keeps old length
    frame_a_fx = 32'd1280; frame_b_fx = 32'd1344; mode_sel = 0;
    do_reset();
    step(5);
    mode_sel = 1;
    step(120);
    chk(vbs_at[0] == 20, "R9 old vrender kept", vbs_at[0], 20);
    chk(vbe_at[0] == 41, "R9 new vblank used", vbe_at[0], 41);
    step(90);
    chk(int'(frame_lines) == LB, "R10 lines per frame B", int'(frame_lines), LB);

    // Sweep: frame lengths and fractions, both modes, mode flipped mid-run
    for (int f = 40; f < 120; f += 2) begin
      for (int k = 0; k < 4; k++) begin
        int fr;
        fr = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 8 : 13;
        frame_a_fx = 32'(f * 16 + fr);
        frame_b_fx = 32'(f * 16 + fr + 96);
        mode_sel = k[0];
        hstat_en = f[1];
        do_reset();
        step(f / 3);
        mode_sel = !mode_sel;
        hstat_clr = 1;
        step(1);
        hstat_clr = 0;
        step(2 * f + 4);
      end
    end

    done = 1;
    summary();
  end
endmodule